// File: doc/BRIEF.md
# Two-Way Data Cache Read Path with Miss-Notify Loads

This block is the load side of a small two-way set-associative data cache. A request carries a byte address and a one-bit load kind. A plain load works as in any cache. A hit answers one cycle after the request is taken. A miss fetches the whole line from a backing memory over a one-beat line port, writes it into the set and then answers with the requested word.

The second kind, the miss-notify load, behaves the same on a hit. On a miss it also emits a one-cycle trap pulse that carries the line-aligned address of the missing line. Surrounding logic can use that pulse to send execution to a user-level handler. The fill still completes, so a retried load to the same line hits. Each set keeps one recency bit that chooses the way to replace.

Top module: `notify_cache`

## Requirements
- R1: On reset every valid bit clears, so the first load to any address after reset misses. While reset is held and in the first cycle after it, `respValid`, `trapValid` and `memReqValid` are 0 and `reqReady` is 1.
- R2: A load taken when its line is resident answers in the next cycle. In that cycle `respValid`=1 and `respHit`=1, and `respData` holds the 32-bit word selected by address bits [5:2] of the line. No memory request is made.
- R3: A plain load that misses raises `memReqValid` from the cycle after it is taken. `memReqAddr` is the request address with bits [5:0] cleared, and the request is held until `memRespValid`. `trapValid` stays 0.
- R4: A miss-notify load that misses drives `trapValid`=1 for exactly one cycle, in the cycle after it is taken. In that cycle `trapAddr` is the request address with bits [5:0] cleared, and the memory request is already active.
- R5: A miss-notify load that hits gives the same response as a plain load, with no trap and no memory request.
- R6: When `memRespValid` is 1 during a fill, the line is written and the next cycle shows `respValid`=1, `respHit`=0 and the requested word. This applies to both load kinds, so a later load to the same line hits.
- R7: `reqReady` is 0 from the cycle after a miss is taken until the fill answers. It is 1 again in the cycle that shows the fill response.
- R8: The geometry is 64-byte lines, 256 sets indexed by address bits [13:6] and two ways. Two lines with the same index and different tags can be resident at once.
- R9: On a fill the victim is way 0 if it is invalid, else way 1 if it is invalid, else the least recently used way. Every hit and every fill marks the touched way as most recent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Load request present |
| reqReady | output | 1 | Cache can take a request this cycle |
| reqAddr | input | 32 | Byte address of the load |
| reqNotify | input | 1 | 1 = miss-notify load, 0 = plain load |
| respValid | output | 1 | Load response present, one cycle |
| respHit | output | 1 | Response came from a hit |
| respData | output | 32 | Loaded word |
| trapValid | output | 1 | One-cycle trap pulse on a miss-notify miss |
| trapAddr | output | 32 | Line-aligned address of the missing line |
| memReqValid | output | 1 | Line fetch request, held until answered |
| memReqAddr | output | 32 | Line-aligned fetch address |
| memRespValid | input | 1 | Fetched line present |
| memRespData | input | 512 | Fetched line, word 0 in the low bits |

## Verification
The bench drives miss-notify loads that hit to catch a design that traps or fetches on a notify hit. It drives miss-notify misses to catch a trap that lasts more than one cycle, points at an unaligned address, or skips the fill and so leaves the retry missing. Conflict sequences in one set catch replacement errors: a design that ignores recency on hits, or prefers the wrong invalid way, evicts a line the bench then expects to hit. A reset in the middle of the run catches valid bits that survive reset and produce false hits.

// File: rtl/notify_cache_pkg.sv
package notify_cache_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic capture;    // latch the request line address and word select
    logic hitAccept;  // request hits: load response word, refresh recency
    logic fillWrite;  // line arrived: write way, set valid, refresh recency
  } ctrlStrobes_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } cacheState_t;

endpackage

// File: rtl/notify_cache_ctrl.sv
module notify_cache_ctrl
  import notify_cache_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqNotify,
  input  logic         lookupHit,
  input  logic         memRespValid,
  output logic         reqReady,
  output logic         memReqValid,
  output logic         respValid,
  output logic         respHit,
  output logic         trapValid,
  output ctrlStrobes_t strb
);

  cacheState_t state, stateNext;

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_FILL);

  always_comb begin
    strb      = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strb.capture = 1'b1;
          if (lookupHit) strb.hitAccept = 1'b1;
          else           stateNext      = ST_FILL;
        end
      end
      ST_FILL: begin
        if (memRespValid) begin
          strb.fillWrite = 1'b1;
          stateNext      = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      respValid <= 1'b0;
      respHit   <= 1'b0;
      trapValid <= 1'b0;
    end else begin
      state     <= stateNext;
      respValid <= strb.hitAccept | strb.fillWrite;
      respHit   <= strb.hitAccept;
      trapValid <= strb.capture & ~lookupHit & reqNotify;
    end
  end

  // R4
  trap_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> !trapValid);

  // R4
  trap_with_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |-> memReqValid);

  // R2
  hit_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && lookupHit) |=> (respValid && respHit && !memReqValid && !trapValid));

  // R3
  plain_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !lookupHit && !reqNotify) |=> (memReqValid && !trapValid && !respValid));

  // R6
  fill_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memRespValid) |=> (respValid && !respHit && reqReady));

endmodule

// File: rtl/notify_cache_datapath.sv
module notify_cache_datapath
  import notify_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 256
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  ctrlStrobes_t              strb,
  input  logic [LINE_BYTES*8-1:0]   memRespData,
  output logic                      lookupHit,
  output logic [DATA_W-1:0]         respData,
  output logic [ADDR_W-1:0]         lineAddrQ
);

  localparam int NUM_WAYS = 2;
  localparam int LINE_W   = LINE_BYTES * 8;
  localparam int OFF_W    = $clog2(LINE_BYTES);
  localparam int IDX_W    = $clog2(SETS);
  localparam int TAG_W    = ADDR_W - IDX_W - OFF_W;
  localparam int WORDS    = LINE_W / DATA_W;
  localparam int WSEL_W   = $clog2(WORDS);
  localparam int BYTE_W   = $clog2(DATA_W / 8);

  typedef logic [WORDS-1:0][DATA_W-1:0] lineWords_t;

  // Request address fields
  logic [TAG_W-1:0]  reqTag;
  logic [IDX_W-1:0]  reqIdx;
  logic [WSEL_W-1:0] reqWsel;
  assign reqTag  = reqAddr[ADDR_W-1 -: TAG_W];
  assign reqIdx  = reqAddr[OFF_W +: IDX_W];
  assign reqWsel = reqAddr[BYTE_W +: WSEL_W];

  // Captured request
  logic [TAG_W-1:0]  tagQ;
  logic [IDX_W-1:0]  idxQ;
  logic [WSEL_W-1:0] wselQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagQ  <= '0;
      idxQ  <= '0;
      wselQ <= '0;
    end else if (strb.capture) begin
      tagQ  <= reqTag;
      idxQ  <= reqIdx;
      wselQ <= reqWsel;
    end
  end

  assign lineAddrQ = {tagQ, idxQ, {OFF_W{1'b0}}};

  // Storage
  logic [LINE_W-1:0] lineMem [NUM_WAYS][SETS];
  logic [TAG_W-1:0]  tagMem  [NUM_WAYS][SETS];
  logic [SETS-1:0]   validBits [NUM_WAYS];
  logic [SETS-1:0]   lruBits;   // per set: way to evict next

  logic [NUM_WAYS-1:0] wayHit;
  logic                victimWay;

  // Victim of the set being filled: invalid way 0, invalid way 1, else recency
  always_comb begin
    if (!validBits[0][idxQ])      victimWay = 1'b0;
    else if (!validBits[1][idxQ]) victimWay = 1'b1;
    else                          victimWay = lruBits[idxQ];
  end

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic wayFill;
    assign wayFill   = strb.fillWrite && (victimWay == 1'(w));
    assign wayHit[w] = validBits[w][reqIdx] && (tagMem[w][reqIdx] == reqTag);

    always_ff @(posedge clk) begin
      if (wayFill) begin
        tagMem[w][idxQ]  <= tagQ;
        lineMem[w][idxQ] <= memRespData;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        validBits[w]       <= '0;
      else if (wayFill) validBits[w][idxQ] <= 1'b1;
    end
  end

  assign lookupHit = |wayHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               lruBits         <= '0;
    else if (strb.hitAccept) lruBits[reqIdx] <= ~wayHit[1];
    else if (strb.fillWrite) lruBits[idxQ]   <= ~victimWay;
  end

  // Response word
  lineWords_t hitWords, fillWords;
  assign hitWords  = wayHit[1] ? lineMem[1][reqIdx] : lineMem[0][reqIdx];
  assign fillWords = memRespData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               respData <= '0;
    else if (strb.hitAccept) respData <= hitWords[reqWsel];
    else if (strb.fillWrite) respData <= fillWords[wselQ];
  end

  // R8
  no_dual_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wayHit[0] && wayHit[1]));

  // R6
  fill_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.fillWrite |=> validBits[$past(victimWay)][$past(idxQ)]);

endmodule

// File: rtl/notify_cache.sv
module notify_cache
  import notify_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 256
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  output logic                     reqReady,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic                     reqNotify,
  output logic                     respValid,
  output logic                     respHit,
  output logic [DATA_W-1:0]        respData,
  output logic                     trapValid,
  output logic [ADDR_W-1:0]        trapAddr,
  output logic                     memReqValid,
  output logic [ADDR_W-1:0]        memReqAddr,
  input  logic                     memRespValid,
  input  logic [LINE_BYTES*8-1:0]  memRespData
);

  ctrlStrobes_t     strb;
  logic             lookupHit;
  logic [ADDR_W-1:0] lineAddrQ;

  notify_cache_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqNotify    (reqNotify),
    .lookupHit    (lookupHit),
    .memRespValid (memRespValid),
    .reqReady     (reqReady),
    .memReqValid  (memReqValid),
    .respValid    (respValid),
    .respHit      (respHit),
    .trapValid    (trapValid),
    .strb         (strb)
  );

  notify_cache_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .LINE_BYTES (LINE_BYTES),
    .SETS       (SETS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .reqAddr     (reqAddr),
    .strb        (strb),
    .memRespData (memRespData),
    .lookupHit   (lookupHit),
    .respData    (respData),
    .lineAddrQ   (lineAddrQ)
  );

  assign trapAddr   = lineAddrQ;
  assign memReqAddr = lineAddrQ;

endmodule

// File: tb/notify_cache_bench.sv
module notify_cache_bench;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqReady;
  logic [31:0]  reqAddr = '0;
  logic         reqNotify = 1'b0;
  logic         respValid, respHit, trapValid, memReqValid;
  logic [31:0]  respData, trapAddr, memReqAddr;
  logic         memRespValid = 1'b0;
  logic [511:0] memRespData = '0;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  notify_cache u_notify_cache (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqNotify(reqNotify), .respValid(respValid),
    .respHit(respHit), .respData(respData), .trapValid(trapValid),
    .trapAddr(trapAddr), .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRespValid(memRespValid), .memRespData(memRespData)
  );

  // Reference model of residency (tags per set and way, recency per set)
  bit          refValid [256][2];
  logic [17:0] refTag   [256][2];
  bit          refLru   [256];

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h6B2F_91C4 ^ {a[13:6], 24'h0};
  endfunction

  function automatic logic [511:0] memLine(input logic [31:0] la);
    logic [511:0] l;
    for (int w = 0; w < 16; w++) l[w*32 +: 32] = memWord({la[31:6], 6'b0} + 32'(w*4));
    return l;
  endfunction

  function automatic int refLookup(input logic [31:0] a);
    for (int w = 0; w < 2; w++)
      if (refValid[a[13:6]][w] && refTag[a[13:6]][w] == a[31:14]) return w;
    return -1;
  endfunction

  task automatic refClear();
    for (int s = 0; s < 256; s++) begin
      refValid[s][0] = 0; refValid[s][1] = 0; refLru[s] = 0;
    end
  endtask

  task automatic refUpdate(input logic [31:0] a);
    int way;
    int s;
    s = int'(a[13:6]);
    way = refLookup(a);
    if (way < 0) begin
      if (!refValid[s][0])      way = 0;
      else if (!refValid[s][1]) way = 1;
      else                      way = refLru[s] ? 1 : 0;
      refValid[s][way] = 1;
      refTag[s][way]   = a[31:14];
    end
    refLru[s] = (way == 0);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One load: drive, sample at the negedge after each relevant edge.
  task automatic doLoad(input logic [31:0] a, input bit n, input int lat, output bit gotHit);
    int  expWay;
    string hr;
    string mr;
    expWay = refLookup(a);
    hr = n ? "R5" : "R2";
    mr = n ? "R4" : "R3";
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqNotify = n;
    @(negedge clk);
    reqValid = 1'b0;
    gotHit = respValid && respHit;
    if (expWay >= 0) begin
      chk(hr, "respValid on hit", 32'(respValid), 32'd1);
      chk(hr, "respHit on hit", 32'(respHit), 32'd1);
      chk(hr, "respData on hit", respData, memWord(a));
      chk(hr, "no trap on hit", 32'(trapValid), 32'd0);
      chk(hr, "no fetch on hit", 32'(memReqValid), 32'd0);
    end else begin
      chk(mr, "no response yet on miss", 32'(respValid), 32'd0);
      chk(mr, "fetch active on miss", 32'(memReqValid), 32'd1);
      chk(mr, "fetch address aligned", memReqAddr, {a[31:6], 6'b0});
      chk(mr, "trap pulse on miss", 32'(trapValid), 32'(n));
      if (n) chk("R4", "trap address aligned", trapAddr, {a[31:6], 6'b0});
      chk("R7", "not ready during fill", 32'(reqReady), 32'd0);
      for (int i = 1; i < lat; i++) begin
        @(negedge clk);
        chk("R3", "fetch held until answered", 32'(memReqValid), 32'd1);
        chk("R4", "trap lasts one cycle", 32'(trapValid), 32'd0);
      end
      memRespValid = 1'b1;
      memRespData  = memLine(memReqAddr);
      @(negedge clk);
      memRespValid = 1'b0;
      chk("R6", "fill respValid", 32'(respValid), 32'd1);
      chk("R6", "fill respHit", 32'(respHit), 32'd0);
      chk("R6", "fill respData", respData, memWord(a));
      chk("R7", "ready after fill", 32'(reqReady), 32'd1);
      chk("R4", "no trap at fill", 32'(trapValid), 32'd0);
    end
    refUpdate(a);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    refClear();
    @(negedge clk);
    chk("R1", "respValid in reset", 32'(respValid), 32'd0);
    chk("R1", "trapValid in reset", 32'(trapValid), 32'd0);
    chk("R1", "memReqValid in reset", 32'(memReqValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "reqReady after reset", 32'(reqReady), 32'd1);
    chk("R1", "memReqValid after reset", 32'(memReqValid), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit h;
    logic [31:0] aA, aB, aC;
    int unsigned seedDummy;
    seedDummy = $urandom(32'd7321);
    refClear();
    doReset();

    // R1: first access misses after reset
    doLoad(32'h0000_1234, 1'b0, 2, h);
    chk("R1", "first load misses", 32'(h), 32'd0);
    // R6: retry of the same line hits
    doLoad(32'h0000_1238, 1'b0, 1, h);
    chk("R6", "retry hits", 32'(h), 32'd1);

    // R4/R6: notify miss then notify retry hits (R5)
    doLoad(32'h00AB_C0C4, 1'b1, 3, h);
    chk("R4", "notify miss reported", 32'(h), 32'd0);
    doLoad(32'h00AB_C0FC, 1'b1, 1, h);
    chk("R5", "notify retry hits", 32'(h), 32'd1);

    // R8/R9: three lines of set 5
    aA = {18'h00011, 8'd5, 6'h08};
    aB = {18'h00022, 8'd5, 6'h10};
    aC = {18'h00033, 8'd5, 6'h3C};
    doLoad(aA, 1'b0, 1, h);
    doLoad(aB, 1'b0, 2, h);
    doLoad(aA, 1'b0, 1, h);
    chk("R8", "both ways resident, A hits", 32'(h), 32'd1);
    doLoad(aB, 1'b1, 1, h);
    chk("R8", "both ways resident, B hits", 32'(h), 32'd1);
    doLoad(aA, 1'b0, 1, h);        // A now most recent
    doLoad(aC, 1'b1, 2, h);        // evicts B
    chk("R9", "third line misses", 32'(h), 32'd0);
    doLoad(aA, 1'b0, 1, h);
    chk("R9", "recent line kept", 32'(h), 32'd1);
    doLoad(aB, 1'b0, 1, h);
    chk("R9", "least recent line evicted", 32'(h), 32'd0);

    // Random mix on a small pool of tags and sets
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      a = {16'h0, 2'($urandom_range(0, 3)), 6'h0, 2'($urandom_range(0, 3)), 6'($urandom)};
      a = {a[31:2], 2'b00};
      doLoad(a, 1'($urandom), int'($urandom_range(1, 4)), h);
    end

    // R1: reset mid-run drops residency
    doReset();
    doLoad(aA, 1'b1, 1, h);
    chk("R1", "resident line misses after reset", 32'(h), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule